// File: doc/BRIEF.md
# Accumulator ALU Datapath

This block is the arithmetic heart of a small processor whose control lines are driven straight from pins by an outside sequencer. A shared data bus supplies one ALU operand. The accumulator register supplies the other operand through a feedback path. Three independent control lines set the operation: an active-low line that keeps only the bus operand, an active-low line that complements the bus operand, and a select that picks bitwise logic or binary arithmetic. The eight combinations give load, add, subtract, negate, AND, NOT and AND-with-complement.

A load strobe writes the ALU result into the accumulator on a rising clock edge. A separate enable drives the accumulator back onto the shared bus through tri-state drivers. When that enable is high, the bus operand is the accumulator itself, so a store-to-bus cycle can also feed the accumulator into its own ALU. The outside sequencer must make sure that only one source drives the bus at a time.

Top module: `acc_alu_datapath`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the accumulator becomes 0. This overrides a load in the same cycle.
- R2: When `load_acc` is low at a rising clock edge, the accumulator keeps its value, whatever the control lines and bus hold.
- R3: With `n_a_only`=0 and `n_invert`=1, a load writes the bus value unchanged into the accumulator. This holds for `logic_sel`=0 and for `logic_sel`=1.
- R4: With `n_a_only`=1, `n_invert`=1 and `logic_sel`=0, a load writes (accumulator + bus) mod 16. The carry-out is lost. For example, 5 then +2 gives 7, and 9+9 gives 2.
- R5: With `n_a_only`=1, `n_invert`=0 and `logic_sel`=0, a load writes (accumulator − bus) mod 16. This is computed as accumulator + ~bus + 1.
- R6: With `n_a_only`=0, `n_invert`=0 and `logic_sel`=0, a load writes the two's-complement negation of the bus value, mod 16.
- R7: With `n_a_only`=1, `n_invert`=1 and `logic_sel`=1, a load writes the bitwise AND of bus and accumulator.
- R8: With `n_a_only`=0, `n_invert`=0 and `logic_sel`=1, a load writes the ones' complement of the bus value.
- R9: With `n_a_only`=1, `n_invert`=0 and `logic_sel`=1, a load writes (~bus) AND accumulator.
- R10: While `acc_to_bus` is 1, `dbus` carries the accumulator value. While it is 0, the block drives nothing, and a value placed on `dbus` by another source reads back unchanged.
- R11: While `acc_to_bus` is 1, the bus operand of the ALU is the accumulator itself. For example, an add with load doubles the accumulator mod 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| n_a_only | input | 1 | Active-low: when 0, the ALU ignores the accumulator operand |
| n_invert | input | 1 | Active-low: when 0, the bus operand is complemented and, in arithmetic, the carry-in is 1 |
| logic_sel | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| load_acc | input | 1 | Writes the ALU result into the accumulator at the clock edge |
| acc_to_bus | input | 1 | Drives the accumulator onto `dbus` |
| dbus | inout | 4 | Shared data bus, which is also ALU operand A |
| acc_q | output | 4 | Current accumulator value |

## Verification
The hardest situation to reach from the ports is the one where the accumulator drives the bus and, in the same cycle, loads a result computed from that same bus value. In that case the ALU sees the accumulator on both operands. To reach it, the stimulus releases its own bus driver whenever it raises `acc_to_bus`. A quarter of the random cycles take this path, and directed cases double the accumulator through it. Directed cases also cover carry wrap, borrow below zero, and a reset that arrives together with a load.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
// Package acc_alu_pkg
// Holds the types shared by the accumulator datapath: the control-line
// bundle and the decoded form of the operation that follows from it.
// Assumes the three control lines are orthogonal, with no opcode encoding.
package acc_alu_pkg;

    // Raw control lines, in the polarity they have at the pins.
    typedef struct packed {
        logic n_a_only;
        logic n_invert;
        logic logic_sel;
    } alu_ctl_t;

    // How the two operands are combined after the operand stage.
    typedef enum logic [1:0] {
        COMB_PASS = 2'd0,
        COMB_AND  = 2'd1,
        COMB_SUM  = 2'd2
    } comb_kind_t;

    // Maps the control lines onto a combine kind.
    // Arithmetic always goes through the adder; in that case the B operand
    // is simply gated to zero when only A is used.
    function automatic comb_kind_t decode_comb(alu_ctl_t c);
        if (!c.logic_sel)
            return COMB_SUM;
        else if (c.n_a_only)
            return COMB_AND;
        else
            return COMB_PASS;
    endfunction

endpackage

// File: rtl/alu_operand_stage.sv
`timescale 1ns/1ps
// Module alu_operand_stage
// Conditions operand A: complements it when the active-low invert line is
// low, and raises the carry-in for arithmetic in that same case.
// Assumes the caller ignores carry_in in logic mode.
module alu_operand_stage #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_raw,
    input  logic         n_invert,
    output logic [W-1:0] a_eff,
    output logic         carry_in
);
    localparam int LAST = W - 1;

    // One XOR per bit: complement every bit while invert is asserted.
    for (genvar i = 0; i <= LAST; i++) begin : g_flip
        assign a_eff[i] = a_raw[i] ^ ~n_invert;
    end

    // Carry-in of one turns the complement into a two's-complement negation.
    assign carry_in = ~n_invert;

endmodule

// File: rtl/alu_combine.sv
`timescale 1ns/1ps
// Module alu_combine
// Combines the conditioned A operand with the accumulator operand B.
// In arithmetic it uses a ripple-carry adder that wraps modulo 2**W.
// In logic it gives either A alone or A AND B.
// Assumes a_eff and carry_in come from alu_operand_stage.
module alu_combine
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_eff,
    input  logic [W-1:0] b_acc,
    input  logic         carry_in,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] result
);
    localparam int LAST = W - 1;

    comb_kind_t   kind;
    logic [W-1:0] b_gated;
    logic [W-1:0] sum;
    logic [W-1:0] carry;

    // Decode the three control lines into a combine kind.
    always_comb kind = decode_comb(ctl);

    // The accumulator operand takes part only when A-only is deasserted.
    assign b_gated = ctl.n_a_only ? b_acc : '0;

    assign carry[0] = carry_in;

    // Ripple-carry adder; the carry out of the top bit is never formed.
    for (genvar i = 0; i <= LAST; i++) begin : g_add
        assign sum[i] = a_eff[i] ^ b_gated[i] ^ carry[i];
        if (i < LAST) begin : g_cy
            assign carry[i+1] = (a_eff[i] & b_gated[i])
                              | (a_eff[i] & carry[i])
                              | (b_gated[i] & carry[i]);
        end
    end

    // Select the final result according to the combine kind.
    always_comb begin
        unique case (kind)
            COMB_SUM: result = sum;
            COMB_AND: result = a_eff & b_acc;
            default:  result = a_eff;
        endcase
    end

endmodule

// File: rtl/acc_register.sv
`timescale 1ns/1ps
// Module acc_register
// The accumulator: a W-bit register with a synchronous active-low clear and
// a load enable. Assumes the reset is synchronous to clk.
module acc_register #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear on reset; otherwise capture d only when load is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/acc_alu_datapath.sv
`timescale 1ns/1ps
// Module acc_alu_datapath
// Top of the accumulator datapath: operand A from the shared bus,
// operand B fed back from the accumulator, result loaded on load_acc, and
// the accumulator driven onto the bus through tri-state drivers when
// acc_to_bus is high. Assumes the outside sequencer lets only one source
// drive dbus at a time.
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         n_a_only,
    input  logic         n_invert,
    input  logic         logic_sel,
    input  logic         load_acc,
    input  logic         acc_to_bus,
    inout  wire  [W-1:0] dbus,
    output logic [W-1:0] acc_q
);
    alu_ctl_t     ctl;
    logic [W-1:0] a_eff;
    logic         cin;
    logic [W-1:0] alu_res;

    // Bundle the pin-level control lines.
    assign ctl = '{n_a_only: n_a_only, n_invert: n_invert, logic_sel: logic_sel};

    // Tri-state driver: the accumulator goes onto the bus only when enabled.
    assign dbus = acc_to_bus ? acc_q : 'z;

    alu_operand_stage #(.W(W)) i_opnd (
        .a_raw    (dbus),
        .n_invert (n_invert),
        .a_eff    (a_eff),
        .carry_in (cin)
    );

    alu_combine #(.W(W)) i_comb (
        .a_eff    (a_eff),
        .b_acc    (acc_q),
        .carry_in (cin),
        .ctl      (ctl),
        .result   (alu_res)
    );

    acc_register #(.W(W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_acc),
        .d     (alu_res),
        .q     (acc_q)
    );

endmodule

// File: rtl/acc_alu_checker.sv
`timescale 1ns/1ps
// Module acc_alu_checker
// Port-level properties of acc_alu_datapath. Each load property recomputes
// the expected result from the requirement, not from the design's logic.
module acc_alu_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         n_a_only,
    input logic         n_invert,
    input logic         logic_sel,
    input logic         load_acc,
    input logic         acc_to_bus,
    input logic [W-1:0] dbus,
    input logic [W-1:0] acc_q
);
    logic past_ok;

    // Marks that at least one clock has passed, so $past is meaningful.
    always_ff @(posedge clk) past_ok <= 1'b1;

    // R1: reset clears the accumulator, whatever the load strobe does.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0);

    // R2: without a load, the accumulator does not change.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !load_acc |=> $stable(acc_q));

    // R3: pass-through in arithmetic mode.
    a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc && !n_a_only && n_invert && !logic_sel
        |=> acc_q == $past(dbus));

    // R4: add, modulo 2**W.
    a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc && n_a_only && n_invert && !logic_sel
        |=> acc_q == W'($past(dbus) + $past(acc_q)));

    // R5: subtract the bus operand from the accumulator.
    a_r5_sub: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc && n_a_only && !n_invert && !logic_sel
        |=> acc_q == W'($past(acc_q) - $past(dbus)));

    // R7: bitwise AND.
    a_r7_and: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc && n_a_only && n_invert && logic_sel
        |=> acc_q == ($past(dbus) & $past(acc_q)));

    // R10: the bus shows the accumulator while the driver is enabled.
    a_r10_bus_drive: assert property (@(posedge clk) disable iff (!rst_n)
        acc_to_bus |-> dbus == acc_q);

endmodule

bind acc_alu_datapath acc_alu_checker #(.W(W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .n_a_only   (n_a_only),
    .n_invert   (n_invert),
    .logic_sel  (logic_sel),
    .load_acc   (load_acc),
    .acc_to_bus (acc_to_bus),
    .dbus       (dbus),
    .acc_q      (acc_q)
);

// File: tb/test_acc_alu_datapath.sv
`timescale 1ns/1ps
module test_acc_alu_datapath;
    localparam int W = 4;
    localparam int CYC = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         n_a_only = 1'b1, n_invert = 1'b1, logic_sel = 1'b0;
    logic         load_acc = 1'b0, acc_to_bus = 1'b0;
    logic         tb_en = 1'b0;
    logic [W-1:0] tb_val = '0;
    wire  [W-1:0] dbus;
    logic [W-1:0] acc_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_acc = '0;

    assign dbus = tb_en ? tb_val : 'z;

    always #(CYC/2) clk = ~clk;

    acc_alu_datapath #(.W(W)) i_acc_alu_datapath (
        .clk(clk), .rst_n(rst_n), .n_a_only(n_a_only), .n_invert(n_invert),
        .logic_sel(logic_sel), .load_acc(load_acc), .acc_to_bus(acc_to_bus),
        .dbus(dbus), .acc_q(acc_q)
    );

    function automatic logic [W-1:0] f_expect(logic [W-1:0] a, logic [W-1:0] b,
                                             logic nao, logic ninv, logic lg);
        logic [W-1:0] aa;
        aa = ninv ? a : ~a;
        if (lg) return nao ? (aa & b) : aa;
        return W'(aa + (nao ? b : '0) + (ninv ? 1'b0 : 1'b1));
    endfunction

    function automatic string f_req(logic nao, logic ninv, logic lg);
        if (!nao && ninv) return "R3";
        if (nao && ninv && !lg) return "R4";
        if (nao && !ninv && !lg) return "R5";
        if (!nao && !ninv && !lg) return "R6";
        if (nao && ninv && lg) return "R7";
        if (!nao && !ninv && lg) return "R8";
        return "R9";
    endfunction

    task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Applies one cycle just after a falling edge, then checks bus and accumulator.
    task automatic do_op(logic nao, logic ninv, logic lg, logic ld, logic oe,
                         logic [W-1:0] val);
        logic [W-1:0] a;
        n_a_only = nao; n_invert = ninv; logic_sel = lg;
        load_acc = ld; acc_to_bus = oe;
        tb_en = !oe; tb_val = val;
        #2;
        if (oe) chk("R10 drive", dbus, m_acc);
        else    chk("R10 release", dbus, val);
        a = oe ? m_acc : val;
        if (ld) m_acc = f_expect(a, m_acc, nao, ninv, lg);
        @(posedge clk); #2;
        chk(ld ? (oe ? "R11" : f_req(nao, ninv, lg)) : "R2", acc_q, m_acc);
        @(negedge clk);
    endtask

    initial begin
        #(CYC * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R1 reset", acc_q, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: load 5, add 2 -> 7
        do_op(0, 1, 0, 1, 0, 4'd5);
        do_op(1, 1, 0, 1, 0, 4'd2);
        chk("R4 five plus two", acc_q, 4'd7);
        // R2 hold with busy controls
        do_op(1, 0, 0, 0, 0, 4'd9);
        // R5 borrow: 7 - 9 = 14
        do_op(1, 0, 0, 1, 0, 4'd9);
        // R4 wrap: load 9, add 9 -> 2
        do_op(0, 1, 1, 1, 0, 4'd9);
        do_op(1, 1, 0, 1, 0, 4'd9);
        // R6 negate 3 -> 13
        do_op(0, 0, 0, 1, 0, 4'd3);
        // R7 AND 13 & 6 = 4
        do_op(1, 1, 1, 1, 0, 4'd6);
        // R8 NOT 5 -> 10
        do_op(0, 0, 1, 1, 0, 4'd5);
        // R9 ~3 & 10 = 8
        do_op(1, 0, 1, 1, 0, 4'd3);
        // R11 doubling through bus: 8+8 -> 0, then load 3, double -> 6
        do_op(1, 1, 0, 1, 1, 4'd0);
        do_op(0, 1, 0, 1, 0, 4'd3);
        do_op(1, 1, 0, 1, 1, 4'd0);
        chk("R11 doubled", acc_q, 4'd6);
        // R1 reset with load asserted
        rst_n = 1'b0;
        n_a_only = 0; n_invert = 1; logic_sel = 0; load_acc = 1;
        acc_to_bus = 0; tb_en = 1; tb_val = 4'd11;
        @(posedge clk); #2;
        chk("R1 reset beats load", acc_q, '0);
        m_acc = '0;
        @(negedge clk);
        rst_n = 1'b1;
        // Random stimulus
        for (int i = 0; i < 400; i++) begin
            do_op(1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) == 0, W'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule